// File: doc/BRIEF.md
# Toffoli Cascade Evaluator

This block runs a stored list of multi-control Toffoli gates over an 8-bit classical basis state. It applies one gate per clock and holds the final state for inspection. Each gate names one target bit and a control mask. The target bit is flipped when every masked bit is 1. An empty mask turns the gate into a plain inverter. Gates are written into a 32-entry store through a simple write port. A start pulse then loads an initial state, and the block walks the store from address 0 to the first empty entry.

When the run ends, the block checks whether the cascade behaves as a clean reversible oracle. The lower bits are the function inputs and must come back unchanged. One bit is the work bit, and the function value is XORed onto it. The upper bits are scratch bits that must start and end at zero. The block reports whether these conditions hold, the function value left on the work bit, and an implementation cost summed over the gates. Each gate's cost depends on how many controls it has.

Top module: `toffoli_cascade_eval`

## Requirements
- R1: With `busy` low, a `wrEn` pulse stores target, mask and valid flag at `wrAddr`. A write made while `busy` is high is discarded, and a later run does not see it.
- R2: A `start` pulse with `busy` low makes `stateOut` equal `initState` in the next cycle. The same pulse clears `totalCost` and `illegalSeen` and raises `busy`. A `start` pulse while `busy` is high has no effect on the run.
- R3: Gates are applied one per clock in address order, beginning at address 0. The run stops after the last valid entry that comes before the first invalid one, or after address 31. With g gates, `done` is seen g cycles after the start edge. When entry 0 is invalid, that delay is 1 cycle.
- R4: A gate XORs the AND of the masked state bits into state bit `target`. All other bits keep their value.
- R5: A gate with mask 0 inverts its target bit.
- R6: A gate whose mask has its own target bit set leaves the state and the cost unchanged. It sets `illegalSeen`, which stays high until the next accepted start.
- R7: `done` is a single-cycle pulse in the cycle after the last gate update, and `busy` falls at the same edge. `stateOut` stays stable while the block is idle.
- R8: Each legal gate adds a cost to `totalCost`, set by its number of controls m. The cost is 0 for m=0, 1 for m=1, 14 for m=2, 56 for m=3 and 140 for m=4. For m of 5 or more, the cost is 112·(m−3).
- R9: Bits 0–3 are inputs, bit 4 is the work bit, and bits 5–7 are scratch. `proper` is 1 exactly when three conditions all hold: the final input bits equal the initial ones, the scratch bits are zero at the end, and the scratch bits were zero at the start. `fValue` is the final work bit XOR the initial work bit.
- R10: After reset, `busy`, `done`, `stateOut`, `totalCost` and `illegalSeen` are all 0, and every store entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Gate store write strobe |
| wrAddr | input | 5 | Store address to write |
| wrTarget | input | 3 | Target bit index of the written gate |
| wrMask | input | 8 | Control mask of the written gate |
| wrValid | input | 1 | Marks the written entry as a gate |
| start | input | 1 | Begin a run from `initState` |
| initState | input | 8 | Initial basis state |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| stateOut | output | 8 | Current or final state |
| proper | output | 1 | Cascade restored inputs and scratch bits |
| fValue | output | 1 | Function value seen on the work bit |
| totalCost | output | 16 | Summed gate cost |
| illegalSeen | output | 1 | A gate with its target in its mask was skipped |

## Verification
A wrong program counter or a wrong update of the state register shows on `stateOut` at the very next clock, because the state is visible every cycle during a run. A wrong end-of-sequence decision moves the `done` pulse by at least one cycle. A wrong cost table entry changes `totalCost` in the cycle after the gate is applied. A broken proper or function calculation shows only when `done` is high, so each oracle input pattern is run to completion and compared against values computed from the R9 bit layout.

// File: rtl/tce_pkg.sv
`timescale 1ns/1ps
package tce_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadInit;   // capture initial state, clear cost and error
    logic applyGate;  // apply the gate currently addressed
  } tceStrobes_t;

  // Implementation cost by control count
  function automatic logic [15:0] gateCost(input int nCtrl);
    logic [15:0] c;
    case (nCtrl)
      0:       c = 16'd0;
      1:       c = 16'd1;
      2:       c = 16'd14;
      3:       c = 16'd56;
      4:       c = 16'd140;
      default: c = 16'(112 * (nCtrl - 3));
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tce_gate_store.sv
`timescale 1ns/1ps
module tce_gate_store #(
  parameter int DEPTH   = 32,
  parameter int STATE_W = 8,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               busy,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [IDX_W-1:0]   wrTarget,
  input  logic [STATE_W-1:0] wrMask,
  input  logic               wrValid,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [IDX_W-1:0]   curTarget,
  output logic [STATE_W-1:0] curMask,
  output logic               curValid,
  output logic               nextValid
);

  logic [IDX_W-1:0]   tgtMem  [DEPTH];
  logic [STATE_W-1:0] maskMem [DEPTH];
  logic               valMem  [DEPTH];
  logic [ADDR_W-1:0]  nextAddr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tgtMem[i]  <= '0;
        maskMem[i] <= '0;
        valMem[i]  <= 1'b0;
      end else if (wrEn && !busy && wrAddr == ADDR_W'(i)) begin
        tgtMem[i]  <= wrTarget;
        maskMem[i] <= wrMask;
        valMem[i]  <= wrValid;
      end
    end
  end

  assign nextAddr  = rdAddr + ADDR_W'(1);
  assign curTarget = tgtMem[rdAddr];
  assign curMask   = maskMem[rdAddr];
  assign curValid  = valMem[rdAddr];
  assign nextValid = valMem[nextAddr];

endmodule

// File: rtl/tce_ctrl.sv
`timescale 1ns/1ps
module tce_ctrl
  import tce_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              curValid,
  input  logic              nextValid,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] rdAddr,
  output tceStrobes_t       strobes
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic              busyQ;
  logic              doneQ;
  logic [ADDR_W-1:0] pc;
  logic              lastStep;

  always_comb begin
    lastStep          = !curValid || (pc == LAST_ADDR) || !nextValid;
    strobes.loadInit  = start && !busyQ;
    strobes.applyGate = busyQ && curValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      pc    <= '0;
    end else begin
      doneQ <= busyQ && lastStep;
      if (!busyQ) begin
        if (start) begin
          busyQ <= 1'b1;
          pc    <= '0;
        end
      end else if (lastStep) begin
        busyQ <= 1'b0;
      end else begin
        pc <= pc + ADDR_W'(1);
      end
    end
  end

  assign busy   = busyQ;
  assign done   = doneQ;
  assign rdAddr = pc;

endmodule

// File: rtl/tce_datapath.sv
`timescale 1ns/1ps
module tce_datapath
  import tce_pkg::*;
#(
  parameter int STATE_W = 8,
  parameter int IDX_W   = 3,
  parameter int NUM_IN  = 4,
  parameter int COST_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  tceStrobes_t        strobes,
  input  logic [STATE_W-1:0] initState,
  input  logic [IDX_W-1:0]   curTarget,
  input  logic [STATE_W-1:0] curMask,
  output logic [STATE_W-1:0] stateOut,
  output logic [COST_W-1:0]  totalCost,
  output logic               illegalSeen,
  output logic               proper,
  output logic               fValue
);

  localparam int WORK_BIT = NUM_IN;
  localparam logic [STATE_W-1:0] IN_MASK  = STATE_W'((64'd1 << NUM_IN) - 64'd1);
  localparam logic [STATE_W-1:0] AUX_MASK = ~STATE_W'((64'd1 << (NUM_IN + 1)) - 64'd1);

  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] initQ;
  logic [COST_W-1:0]  costQ;
  logic               illQ;
  logic               gateIllegal;
  logic               andTerm;
  logic [STATE_W-1:0] gatedState;
  logic [COST_W-1:0]  stepCost;

  always_comb begin
    gateIllegal = curMask[curTarget];
    andTerm     = &(stateQ | ~curMask);
    gatedState  = stateQ;
    gatedState[curTarget] = stateQ[curTarget] ^ andTerm;
    stepCost    = COST_W'(gateCost($countones(curMask)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= '0;
      initQ  <= '0;
      costQ  <= '0;
      illQ   <= 1'b0;
    end else if (strobes.loadInit) begin
      stateQ <= initState;
      initQ  <= initState;
      costQ  <= '0;
      illQ   <= 1'b0;
    end else if (strobes.applyGate) begin
      if (gateIllegal) begin
        illQ <= 1'b1;
      end else begin
        stateQ <= gatedState;
        costQ  <= costQ + stepCost;
      end
    end
  end

  assign stateOut    = stateQ;
  assign totalCost   = costQ;
  assign illegalSeen = illQ;
  assign proper      = (((stateQ ^ initQ) & IN_MASK) == '0)
                    && ((stateQ & AUX_MASK) == '0)
                    && ((initQ & AUX_MASK) == '0);
  assign fValue      = stateQ[WORK_BIT] ^ initQ[WORK_BIT];

endmodule

// File: rtl/toffoli_cascade_eval.sv
`timescale 1ns/1ps
module toffoli_cascade_eval
  import tce_pkg::*;
#(
  parameter int STATE_W = 8,
  parameter int DEPTH   = 32,
  parameter int NUM_IN  = 4,
  parameter int COST_W  = 16,
  parameter int IDX_W   = $clog2(STATE_W),
  parameter int ADDR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [IDX_W-1:0]   wrTarget,
  input  logic [STATE_W-1:0] wrMask,
  input  logic               wrValid,
  input  logic               start,
  input  logic [STATE_W-1:0] initState,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] stateOut,
  output logic               proper,
  output logic               fValue,
  output logic [COST_W-1:0]  totalCost,
  output logic               illegalSeen
);

  tceStrobes_t        strobes;
  logic [ADDR_W-1:0]  rdAddr;
  logic [IDX_W-1:0]   curTarget;
  logic [STATE_W-1:0] curMask;
  logic               curValid;
  logic               nextValid;

  tce_gate_store #(
    .DEPTH(DEPTH), .STATE_W(STATE_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .busy(busy),
    .wrAddr(wrAddr), .wrTarget(wrTarget), .wrMask(wrMask), .wrValid(wrValid),
    .rdAddr(rdAddr), .curTarget(curTarget), .curMask(curMask),
    .curValid(curValid), .nextValid(nextValid)
  );

  tce_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .curValid(curValid), .nextValid(nextValid),
    .busy(busy), .done(done), .rdAddr(rdAddr), .strobes(strobes)
  );

  tce_datapath #(
    .STATE_W(STATE_W), .IDX_W(IDX_W), .NUM_IN(NUM_IN), .COST_W(COST_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .initState(initState),
    .curTarget(curTarget), .curMask(curMask),
    .stateOut(stateOut), .totalCost(totalCost), .illegalSeen(illegalSeen),
    .proper(proper), .fValue(fValue)
  );

endmodule

// File: rtl/tce_checker.sv
`timescale 1ns/1ps
module tce_checker #(
  parameter int STATE_W = 8,
  parameter int COST_W  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [STATE_W-1:0] initState,
  input logic               busy,
  input logic               done,
  input logic [STATE_W-1:0] stateOut,
  input logic [COST_W-1:0]  totalCost,
  input logic               illegalSeen
);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && stateOut == $past(initState)
                          && totalCost == '0 && !illegalSeen));

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(stateOut));

  // R6
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (illegalSeen && !(start && !busy)) |=> illegalSeen);

  // R8
  cost_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (totalCost >= $past(totalCost)));

endmodule

bind toffoli_cascade_eval tce_checker #(
  .STATE_W(STATE_W), .COST_W(COST_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .initState(initState),
  .busy(busy), .done(done), .stateOut(stateOut),
  .totalCost(totalCost), .illegalSeen(illegalSeen)
);

// File: tb/toffoli_cascade_eval_bench.sv
`timescale 1ns/1ps
module toffoli_cascade_eval_bench;

  localparam int DEP = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [2:0] wrTarget = '0;
  logic [7:0] wrMask = '0;
  logic       wrValid = 1'b0;
  logic       start = 1'b0;
  logic [7:0] initState = '0;
  logic       busy, done, proper, fValue, illegalSeen;
  logic [7:0] stateOut;
  logic [15:0] totalCost;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  toffoli_cascade_eval u_toffoli_cascade_eval (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrTarget(wrTarget), .wrMask(wrMask), .wrValid(wrValid),
    .start(start), .initState(initState), .busy(busy), .done(done),
    .stateOut(stateOut), .proper(proper), .fValue(fValue),
    .totalCost(totalCost), .illegalSeen(illegalSeen)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int refCost(input int m);
    if (m == 0) return 0;
    if (m == 1) return 1;
    if (m == 2) return 14;
    if (m == 3) return 56;
    if (m == 4) return 140;
    return 112 * (m - 3);
  endfunction

  // Behavioural reference model
  logic [2:0] mTgt [DEP];
  logic [7:0] mMask[DEP];
  logic       mVal [DEP];
  int         gateQ[$];
  logic       mBusy, mDone, mIll, wasBusy;
  logic [7:0] mState, mInit;
  int         mCost;

  task automatic refApply(input int idx);
    logic allOnes;
    int   nCtl;
    if (mMask[idx][mTgt[idx]]) begin
      mIll = 1'b1;
    end else begin
      allOnes = 1'b1;
      nCtl = 0;
      for (int k = 0; k < 8; k++) begin
        if (mMask[idx][k]) begin
          nCtl++;
          if (!mState[k]) allOnes = 1'b0;
        end
      end
      if (allOnes) mState[mTgt[idx]] = ~mState[mTgt[idx]];
      mCost = mCost + refCost(nCtl);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mIll = 0; mState = '0; mInit = '0; mCost = 0;
      gateQ.delete();
      for (int i = 0; i < DEP; i++) begin
        mTgt[i] = '0; mMask[i] = '0; mVal[i] = 1'b0;
      end
    end else begin
      wasBusy = mBusy;
      if (!wasBusy && wrEn) begin
        mTgt[wrAddr] = wrTarget; mMask[wrAddr] = wrMask; mVal[wrAddr] = wrValid;
      end
      if (wasBusy) begin
        if (gateQ.size() > 0) refApply(gateQ.pop_front());
        mDone = (gateQ.size() == 0);
        if (mDone) mBusy = 0;
      end else begin
        mDone = 0;
        if (start) begin
          gateQ.delete();
          for (int i = 0; i < DEP; i++) begin
            if (!mVal[i]) break;
            gateQ.push_back(i);
          end
          mBusy = 1; mState = initState; mInit = initState; mCost = 0; mIll = 0;
        end
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      chk("R7", "busy vs model", 32'(busy), 32'(mBusy));
      chk("R7", "done vs model", 32'(done), 32'(mDone));
      chk("R4", "state vs model", 32'(stateOut), 32'(mState));
      chk("R8", "cost vs model", 32'(totalCost), 32'(mCost));
      chk("R6", "illegal vs model", 32'(illegalSeen), 32'(mIll));
      if (mDone) begin
        chk("R9", "proper vs model", 32'(proper),
            32'((((mState ^ mInit) & 8'h0F) == 0) && ((mState & 8'hE0) == 0)
                && ((mInit & 8'hE0) == 0)));
        chk("R9", "fValue vs model", 32'(fValue), 32'(mState[4] ^ mInit[4]));
      end
    end
  end

  task automatic writeGate(input int addr, input int tgt, input logic [7:0] m,
                           input logic v);
    wrEn = 1'b1; wrAddr = 5'(addr); wrTarget = 3'(tgt); wrMask = m; wrValid = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic clearProg();
    for (int i = 0; i < DEP; i++) writeGate(i, 0, 8'h00, 1'b0);
  endtask

  task automatic runIt(input logic [7:0] init, output int cyc);
    initState = init;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (done) break;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    logic f;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "busy", 32'(busy), 0);
    chk("R10", "done", 32'(done), 0);
    chk("R10", "stateOut", 32'(stateOut), 0);
    chk("R10", "totalCost", 32'(totalCost), 0);
    chk("R10", "illegalSeen", 32'(illegalSeen), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 R10: empty store, zero-gate run
    runIt(8'h3C, cyc);
    chk("R3", "zero-gate cycles", 32'(cyc), 1);
    chk("R3", "zero-gate state", 32'(stateOut), 32'h3C);
    chk("R8", "zero-gate cost", 32'(totalCost), 0);

    // R1 R4 R9: x0&x1&x2 oracle through scratch bit 5
    writeGate(0, 5, 8'h03, 1'b1);
    writeGate(1, 4, 8'h24, 1'b1);
    writeGate(2, 5, 8'h03, 1'b1);
    for (int x = 0; x < 16; x++) begin
      f = x[0] & x[1] & x[2];
      runIt(8'(x), cyc);
      chk("R3", "oracle cycles", 32'(cyc), 3);
      chk("R4", "oracle state", 32'(stateOut), 32'(x | (int'(f) << 4)));
      chk("R9", "oracle proper", 32'(proper), 1);
      chk("R9", "oracle fValue", 32'(fValue), 32'(f));
      chk("R8", "oracle cost", 32'(totalCost), 42);
      if (x == 0) begin
        @(negedge clk);
        chk("R7", "done one cycle", 32'(done), 0);
        chk("R7", "idle busy", 32'(busy), 0);
        chk("R7", "state held", 32'(stateOut), 0);
      end
    end
    runIt(8'h17, cyc);
    chk("R9", "work preset state", 32'(stateOut), 32'h07);
    chk("R9", "work preset fValue", 32'(fValue), 1);
    runIt(8'h23, cyc);
    chk("R9", "dirty scratch proper", 32'(proper), 0);
    chk("R4", "dirty scratch state", 32'(stateOut), 32'h23);

    // R9: cascade disturbs an input
    clearProg();
    writeGate(0, 0, 8'h02, 1'b1);
    runIt(8'h02, cyc);
    chk("R4", "cnot state", 32'(stateOut), 32'h03);
    chk("R9", "input changed proper", 32'(proper), 0);
    chk("R8", "one-control cost", 32'(totalCost), 1);

    // R5: empty mask inverts
    writeGate(0, 4, 8'h00, 1'b1);
    runIt(8'h05, cyc);
    chk("R5", "inverter state", 32'(stateOut), 32'h15);
    chk("R5", "inverter fValue", 32'(fValue), 1);
    chk("R8", "inverter cost", 32'(totalCost), 0);

    // R6: illegal gate skipped
    writeGate(0, 2, 8'h04, 1'b1);
    writeGate(1, 4, 8'h01, 1'b1);
    runIt(8'h01, cyc);
    chk("R6", "illegal cycles", 32'(cyc), 2);
    chk("R6", "illegal state", 32'(stateOut), 32'h11);
    chk("R6", "illegal flag", 32'(illegalSeen), 1);
    chk("R6", "illegal cost", 32'(totalCost), 1);

    // R2: load visible one cycle after start, flag cleared
    initState = 8'h05; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "loaded state", 32'(stateOut), 32'h05);
    chk("R2", "busy raised", 32'(busy), 1);
    chk("R2", "flag cleared", 32'(illegalSeen), 0);
    chk("R2", "cost cleared", 32'(totalCost), 0);
    repeat (4) @(negedge clk);

    // R8: cost for 1..7 controls
    clearProg();
    for (int i = 0; i < 7; i++) writeGate(i, 7, 8'((1 << (i + 1)) - 1), 1'b1);
    runIt(8'h00, cyc);
    chk("R8", "cost table sum", 32'(totalCost), 1219);
    chk("R3", "seven-gate cycles", 32'(cyc), 7);

    // R3: full store ends at last address
    for (int i = 0; i < DEP; i++) writeGate(i, 4, 8'h00, 1'b1);
    runIt(8'h0A, cyc);
    chk("R3", "full store cycles", 32'(cyc), 32);
    chk("R3", "full store state", 32'(stateOut), 32'h0A);

    // R1 R2: write and start during a run are ignored
    initState = 8'h0A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    writeGate(5, 0, 8'h00, 1'b0);
    initState = 8'h55; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 2;
    while (cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (done) break;
    end
    chk("R2", "start while busy ignored", 32'(cyc), 32);
    chk("R2", "state from first start", 32'(stateOut), 32'h0A);
    runIt(8'h0A, cyc);
    chk("R1", "busy write discarded", 32'(cyc), 32);

    summary();
    $finish;
  end

endmodule